// File: doc/BRIEF.md
# Eye Row Minimum Locator

This peripheral takes a cropped face region from a DMA stream, one 8-bit gray pixel per clock, and reduces it to a vertical brightness profile. Each image row becomes one sum. The block scans those sums from the top of the region and looks for rows that are darker than both of their neighbours. It reports the row index of one chosen dip as the eye position.

The host sets up a run through a small write port. It sets the row width, the number of rows, a minimum dip depth and a day/night mode bit. It then writes the restart register and streams the region. When the last pixel of the last row has been accepted, the block latches its result and raises a level interrupt. Night operation selects the second qualifying dip and day operation selects the third. If the region holds too few dips, a not-found flag is set instead.

Top module: `eye_row_locator`

## Requirements
- R1: After the asynchronous reset, the interrupt is low, the status word (read address 1) is zero and the result (read address 0) is zero.
- R2: Each row sum is the 16-bit total of exactly `width` accepted pixels, where `width` is set by a write to address 1. Row boundaries follow the programmed width, not any pixel value.
- R3: A row qualifies as a dip only if its sum is strictly below the sums of the rows directly above and below it, and each of those two sums exceeds it by at least the depth threshold (written to address 3). The first and last rows never qualify.
- R4: Dips are counted from the top. With the mode bit (address 4, bit 0) set to 1 (night), the second dip's row index is reported at read address 0. With it at 0 (day), the third dip's row index is reported.
- R5: If the region ends with fewer dips than the mode requires, status bit 1 (not found) is set and the result reads zero.
- R6: On the clock edge that accepts the last pixel of the last row (row count written to address 2), status bit 0 (done) and the interrupt rise together, and status bit 2 mirrors the interrupt. Cycles with `pix_valid` low are not counted as pixels.
- R7: Once done, the result and status do not change, and further pixels are ignored, until a restart write.
- R8: The interrupt stays high until a write to address 5 clears it. That write leaves the result and the done and not-found bits unchanged.
- R9: A write to address 0 clears the row sums, counters, result, status and interrupt. It keeps the programmed width, row count, threshold and mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | A pixel is presented this cycle |
| pix_data | input | 8 | Gray pixel value |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write address: 0 restart, 1 width, 2 rows, 3 depth, 4 mode, 5 interrupt clear |
| reg_wdata | input | 16 | Write data |
| rd_addr | input | 3 | Read address: 0 result row, 1 status |
| rd_data | output | 16 | Read data for `rd_addr`, combinational |
| irq | output | 1 | Result-ready interrupt, level high |

## Verification
The same eight-row profile is streamed under both modes and under several depth thresholds:
- The two modes tell the second dip from the third.
- A threshold set exactly at a dip's shallower side, and one count above it, pins down the inclusive comparison.
- A large threshold removes dips until the day selection finds nothing.

A profile with a plateau, and with its darkest rows at the top and bottom edges, shows that neither equal neighbours nor edge rows count as dips.

A two-pixel-wide region whose per-pixel values mislead but whose row sums do not shows that the decision rests on sums over the programmed width. A gapped stream shows that idle cycles are not counted.

Pixels sent after completion, interrupt clears and a restart in mid-region exercise the hold and clear rules.

// File: rtl/eye_row_locator.sv
module eye_row_locator #(
  parameter int PIX_W     = 8,
  parameter int SUM_W     = 16,
  parameter int COL_W     = 9,
  parameter int ROW_W     = 8,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 16,
  parameter int DEF_WIDTH = 64,
  parameter int DEF_ROWS  = 48,
  parameter int NIGHT_IDX = 2,
  parameter int DAY_IDX   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_RESTART = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_WIDTH   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ROWS    = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DEPTH   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_MODE    = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_ACK     = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] R_RESULT  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] R_STATUS  = ADDR_W'(1);
  localparam int IDX_MAX = (DAY_IDX > NIGHT_IDX) ? DAY_IDX : NIGHT_IDX;
  localparam int CNT_W   = $clog2(IDX_MAX + 1);

  logic [COL_W-1:0] width_q;
  logic [ROW_W-1:0] rows_q;
  logic [SUM_W-1:0] thr_q;
  logic             mode_q;

  logic [SUM_W-1:0] acc_q, prev_q, prev2_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] cnt_q;
  logic             found_q, done_q, nf_q;
  logic [ROW_W-1:0] res_q;

  wire restart = reg_we && reg_addr == A_RESTART;
  wire ack     = reg_we && reg_addr == A_ACK;
  wire take    = pix_valid && !done_q;
  wire row_end = take && col_q == width_q - COL_W'(1);
  wire last    = row_q == rows_q - ROW_W'(1);

  wire [SUM_W-1:0] row_sum = acc_q + SUM_W'(pix_data);

  wire above_ok = prev_q < prev2_q  && (prev2_q - prev_q) >= thr_q;
  wire below_ok = prev_q < row_sum  && (row_sum - prev_q) >= thr_q;
  wire is_min   = row_end && row_q >= ROW_W'(2) && above_ok && below_ok;

  wire [CNT_W-1:0] sel = mode_q ? CNT_W'(NIGHT_IDX) : CNT_W'(DAY_IDX);
  wire hit = is_min && !found_q && (cnt_q + CNT_W'(1)) == sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= COL_W'(DEF_WIDTH);
      rows_q  <= ROW_W'(DEF_ROWS);
      thr_q   <= '0;
      mode_q  <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        A_WIDTH: width_q <= reg_wdata[COL_W-1:0];
        A_ROWS:  rows_q  <= reg_wdata[ROW_W-1:0];
        A_DEPTH: thr_q   <= reg_wdata[SUM_W-1:0];
        A_MODE:  mode_q  <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0; prev_q <= '0; prev2_q <= '0;
      col_q <= '0; row_q <= '0; cnt_q <= '0;
      found_q <= 1'b0; done_q <= 1'b0; nf_q <= 1'b0;
      res_q <= '0; irq <= 1'b0;
    end else if (restart) begin
      acc_q <= '0; prev_q <= '0; prev2_q <= '0;
      col_q <= '0; row_q <= '0; cnt_q <= '0;
      found_q <= 1'b0; done_q <= 1'b0; nf_q <= 1'b0;
      res_q <= '0; irq <= 1'b0;
    end else begin
      if (ack) irq <= 1'b0;
      if (take) begin
        if (row_end) begin
          acc_q   <= '0;
          col_q   <= '0;
          prev2_q <= prev_q;
          prev_q  <= row_sum;
          row_q   <= row_q + ROW_W'(1);
          if (hit) begin
            found_q <= 1'b1;
            res_q   <= row_q - ROW_W'(1);
          end else if (is_min && !found_q) begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
          if (last) begin
            done_q <= 1'b1;
            irq    <= 1'b1;
            nf_q   <= !(found_q || hit);
          end
        end else begin
          acc_q <= row_sum;
          col_q <= col_q + COL_W'(1);
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      R_RESULT: rd_data[ROW_W-1:0] = res_q;
      R_STATUS: rd_data[2:0] = {irq, nf_q, done_q};
      default: ;
    endcase
  end
endmodule

// File: rtl/eye_row_locator_chk.sv
module eye_row_locator_chk #(
  parameter int ADDR_W = 3,
  parameter int ROW_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              pix_valid,
  input logic              irq,
  input logic              done,
  input logic              nf,
  input logic [ROW_W-1:0]  res
);
  wire wr_restart = reg_we && reg_addr == ADDR_W'(0);
  wire wr_ack     = reg_we && reg_addr == ADDR_W'(5);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !wr_restart && !wr_ack |=> irq);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !wr_restart |=> done && $stable(res) && $stable(nf));

  // R5
  nf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nf |-> done && res == '0);

  // R6
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(pix_valid) && irq);

  // R9
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_restart |=> !done && !irq && !nf && res == '0);
endmodule

bind eye_row_locator eye_row_locator_chk #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .pix_valid(pix_valid), .irq(irq), .done(done_q), .nf(nf_q), .res(res_q)
);

// File: tb/eye_row_locator_tb.sv
module eye_row_locator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_data = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;

  int m_w = 64, m_rows = 48, m_thr = 0, m_mode = 0;
  int m_acc = 0, m_col = 0, m_cnt = 0, m_res = 0;
  bit m_found = 0, m_done = 0, m_nf = 0, m_irq = 0;
  int sums[$];
  int prof[$];

  always #10 clk = ~clk;

  eye_row_locator u_dut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int read_reg(int a);
    return 0;
  endfunction

  task automatic compare();
    check("R8", int'(irq), int'(m_irq), "irq");
    rd_addr = 3'd0; #1;
    check("R4", int'(rd_data), m_res, "result");
    rd_addr = 3'd1; #1;
    check("R6", int'(rd_data), (int'(m_irq) << 2) | (int'(m_nf) << 1) | int'(m_done), "status");
  endtask

  task automatic model_step(bit v, int px, bit we, int a, int d);
    if (we && a == 0) begin
      m_acc = 0; m_col = 0; m_cnt = 0; m_res = 0;
      m_found = 0; m_done = 0; m_nf = 0; m_irq = 0;
      sums.delete();
      return;
    end
    if (we) begin
      case (a)
        1: m_w = d;
        2: m_rows = d;
        3: m_thr = d;
        4: m_mode = d & 1;
        5: m_irq = 0;
        default: ;
      endcase
    end
    if (v && !m_done) begin
      m_acc = (m_acc + px) % 65536;
      m_col++;
      if (m_col == m_w) begin
        int n;
        sums.push_back(m_acc);
        m_acc = 0; m_col = 0;
        n = sums.size();
        if (n >= 3) begin
          int up, mid, dn;
          up = sums[n-3]; mid = sums[n-2]; dn = sums[n-1];
          if (mid < up && mid < dn && up - mid >= m_thr && dn - mid >= m_thr && !m_found) begin
            m_cnt++;
            if (m_cnt == (m_mode ? 2 : 3)) begin
              m_found = 1;
              m_res = n - 2;
            end
          end
        end
        if (n == m_rows) begin
          m_done = 1; m_irq = 1; m_nf = !m_found;
        end
      end
    end
  endtask

  task automatic cyc(bit v, int px, bit we, int a, int d);
    pix_valid = v; pix_data = px[7:0];
    reg_we = we; reg_addr = a[2:0]; reg_wdata = d[15:0];
    @(posedge clk);
    #1 model_step(v, px, we, a, d);
    @(negedge clk);
    pix_valid = 1'b0; reg_we = 1'b0;
    compare();
  endtask

  task automatic wreg(int a, int d);
    cyc(0, 0, 1, a, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 8'hAA, 0, 0, 0);
  endtask

  task automatic run_uniform(int mode, int thr, bit gap);
    wreg(0, 0);
    wreg(3, thr);
    wreg(4, mode);
    wreg(2, prof.size());
    foreach (prof[r]) begin
      for (int i = 0; i < m_w; i++) begin
        cyc(1, prof[r], 0, 0, 0);
        if (gap) cyc(0, 8'hFF, 0, 0, 0);
      end
    end
  endtask

  task automatic expect_end(string req, int res, int status);
    rd_addr = 3'd0; #1;
    check(req, int'(rd_data), res, "final result");
    rd_addr = 3'd1; #1;
    check(req, int'(rd_data), status, "final status");
  endtask

  task automatic profile_a();
    prof.delete();
    prof = '{50, 30, 40, 20, 45, 10, 35, 60};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R6 watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(irq), 0, "irq after reset");
    expect_end("R1", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    wreg(1, 4);
    profile_a();
    // R4 night: second dip is row 3
    run_uniform(1, 0, 0);
    expect_end("R4", 3, 5);

    // R7: pixels after done ignored
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 0);
    expect_end("R7", 3, 5);

    // R8: irq held, then cleared by ack; result kept
    idle(4);
    check("R8", int'(irq), 1, "irq held");
    wreg(5, 0);
    check("R8", int'(irq), 0, "irq after ack");
    expect_end("R8", 3, 1);

    // R4 day: third dip is row 5
    run_uniform(0, 0, 0);
    expect_end("R4", 5, 5);

    // R3 threshold 60 removes the row-1 dip
    run_uniform(1, 60, 0);
    expect_end("R3", 5, 5);

    // R5 day with threshold 60: only two dips
    run_uniform(0, 60, 0);
    expect_end("R5", 0, 7);

    // R3 inclusive depth boundary: row-1 shallow side is 40
    run_uniform(1, 40, 0);
    expect_end("R3", 3, 5);
    run_uniform(1, 41, 0);
    expect_end("R3", 5, 5);

    // R3 plateau and edge rows never qualify
    prof.delete();
    prof = '{10, 50, 30, 30, 50, 20, 60, 5};
    run_uniform(1, 0, 0);
    expect_end("R3", 0, 7);

    // R6 gapped stream gives the same answer
    profile_a();
    run_uniform(1, 0, 1);
    expect_end("R6", 3, 5);

    // R2 width 2, sums decide, not single pixels
    wreg(1, 2);
    wreg(0, 0);
    wreg(3, 0);
    wreg(4, 1);
    wreg(2, 5);
    begin
      int px[10] = '{50, 50, 10, 60, 40, 40, 5, 70, 50, 50};
      for (int i = 0; i < 10; i++) cyc(1, px[i], 0, 0, 0);
    end
    expect_end("R2", 3, 5);

    // R9 restart mid-region clears state, keeps configuration
    wreg(1, 4);
    profile_a();
    wreg(0, 0);
    wreg(4, 1);
    wreg(2, 8);
    for (int i = 0; i < 10; i++) cyc(1, prof[i / 4], 0, 0, 0);
    wreg(0, 0);
    check("R9", int'(irq), 0, "irq after restart");
    expect_end("R9", 0, 0);
    foreach (prof[r]) for (int i = 0; i < 4; i++) cyc(1, prof[r], 0, 0, 0);
    expect_end("R9", 3, 5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule